// File: doc/BRIEF.md
# Write-Update Snoop Coherence Controller

This block keeps one direct-mapped write-back cache coherent with its peers on a shared bus by updating their copies rather than invalidating them. Every resident line is in one of four states: exclusive-clean, shared-clean, shared-owned (shared and dirty, this cache answers for it) or dirty-private. A line that is not resident has no state of its own and is simply absent. When the processor writes a line that other caches may hold, the controller puts the written word on the bus as an update, together with its word offset and byte mask. When another cache's update is snooped, the word is merged into the local copy.

The processor holds a request until `cpuReady` pulses. Hits are answered in the cycle they are presented. A miss may first write back a dirty victim, then fetches the line with a bus read and then looks the request up again. The bus side is a single outstanding request that stays up until the fabric returns `busDone`, with the wired-OR shared line sampled in that same cycle. Snooped transactions are answered combinationally: the shared line and, for a dirty line, the whole line as a flush.

Top module: `snoopUpdateCtrl`

## Requirements
- R1: After reset every line is absent, no bus request is raised, no snoop response is given, and the first access to any address misses.
- R2: A read miss raises a bus read (command code 1) for the line address. At `busDone` it installs `busFill` as shared-clean if `busShared` is high, or as exclusive-clean if it is low. The request then completes in the following cycle with `cpuHit` low and the filled word.
- R3: A read to a resident line completes in the same cycle with `cpuHit` high and the stored word, with no bus request and no change of state.
- R4: A write to a shared-clean or shared-owned line raises a bus update (command code 2) that carries the word offset, the byte mask and the data. At `busDone` the request completes, the bytes are merged locally, and the line becomes shared-owned if `busShared` is high, or dirty-private if it is low.
- R5: A write to an exclusive-clean or dirty-private line completes in the same cycle with no bus request, and the line becomes dirty-private.
- R6: A snooped read (code 1) that hits a resident line raises `snpSharedOut`. If the line is dirty-private or shared-owned, the snooped read also raises `snpFlush` with the full line, and the line becomes shared-owned. An exclusive-clean line becomes shared-clean.
- R7: A snooped update (code 2) that hits a resident line raises `snpSharedOut` and merges the enabled bytes into the addressed word. A shared-owned holder drops to shared-clean.
- R8: A write miss first raises a bus read. If the line is installed shared, the write then raises a bus update and ends shared-owned. Otherwise it ends dirty-private with no further bus traffic.
- R9: A miss whose indexed line holds another tag in a dirty state first raises a write-back (code 3) with the victim's line address and full line, and only then the bus read. A clean victim is dropped silently.
- R10: A raised bus request keeps its command and address unchanged until `busDone`.
- R11: A snoop is served only while no own bus request is raised. It takes the cycle, so no processor request completes in it. While a bus request is raised, snoops give no response and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address: tag, index, word offset |
| cpuWdata | input | DATA_W | Write data |
| cpuBe | input | DATA_W/8 | Write byte enables |
| cpuReady | output | 1 | Request completes this cycle |
| cpuHit | output | 1 | With cpuReady: 1 if the first lookup hit |
| cpuRdata | output | DATA_W | With cpuReady on a read: the word |
| busValid | output | 1 | Bus request raised |
| busCmd | output | 2 | 1 read, 2 update, 3 write-back |
| busAddr | output | ADDR_W-log2(WORDS) | Line address of the request |
| busWord | output | log2(WORDS) | Word offset of an update |
| busBe | output | DATA_W/8 | Byte mask of an update |
| busWdata | output | DATA_W | Data word of an update |
| busLine | output | DATA_W*WORDS | Line data of a write-back |
| busDone | input | 1 | Request finished this cycle |
| busShared | input | 1 | Wired-OR shared line, sampled with busDone |
| busFill | input | DATA_W*WORDS | Line data returned for a read |
| snpValid | input | 1 | Snooped transaction present |
| snpCmd | input | 2 | 1 read, 2 update |
| snpAddr | input | ADDR_W-log2(WORDS) | Snooped line address |
| snpWord | input | log2(WORDS) | Word offset of a snooped update |
| snpBe | input | DATA_W/8 | Byte mask of a snooped update |
| snpData | input | DATA_W | Data word of a snooped update |
| snpSharedOut | output | 1 | This cache holds the snooped line |
| snpFlush | output | 1 | Full line supplied for a snooped read |
| snpFlushLine | output | DATA_W*WORDS | The flushed line |

## Verification
Hits and snoop responses are combinational, so they are due in the very cycle their inputs are applied. State changes show up from the next cycle on. A bus request appears one cycle after the missing or shared write is presented, and it ends in the `busDone` cycle. A refilled request completes one cycle after that. The bench drives inputs half a period away from the edge, advances a behavioural model at each rising edge with the same inputs, and compares every output against the model one time unit after the inputs settle. A change of state is therefore judged by the outputs it produces in later cycles.

// File: rtl/snoopUpdatePkg.sv
package snoopUpdatePkg;

  typedef enum logic [2:0] {
    LS_NP = 3'd0,
    LS_E  = 3'd1,
    LS_SC = 3'd2,
    LS_SM = 3'd3,
    LS_M  = 3'd4
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_UPD  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_t;

  typedef struct packed {
    logic       cpuWrWord;
    logic       cpuSetState;
    lineState_t cpuNewState;
    logic       install;
    lineState_t installState;
    logic       evict;
    logic       selVictim;
    logic       snpWrWord;
    logic       snpSetState;
    lineState_t snpNewState;
  } ctrlStrobes_t;

  function automatic logic isDirty(input lineState_t s);
    return (s == LS_M) || (s == LS_SM);
  endfunction

endpackage

// File: rtl/snoopUpdateData.sv
module snoopUpdateData
  import snoopUpdatePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W,
  localparam int LA_W   = ADDR_W - OFS_W,
  localparam int LINE_W = DATA_W * WORDS,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BE_W-1:0]   cpuBe,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [LA_W-1:0]   snpAddr,
  input  logic [OFS_W-1:0]  snpWord,
  input  logic [BE_W-1:0]   snpBe,
  input  logic [DATA_W-1:0] snpData,
  output logic              cpuMatch,
  output lineState_t        cpuVicState,
  output lineState_t        snpState,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [LA_W-1:0]   reqAddr,
  output logic [LINE_W-1:0] victimLine,
  output logic [LINE_W-1:0] snpLine
);

  lineState_t              stateQ [LINES];
  logic [TAG_W-1:0]        tagQ   [LINES];
  logic [LINE_W-1:0]       dataQ  [LINES];

  logic [OFS_W-1:0] cpuOfs;
  logic [IDX_W-1:0] cpuIdx;
  logic [TAG_W-1:0] cpuTag;
  logic [IDX_W-1:0] snpIdx;
  logic [TAG_W-1:0] snpTag;

  assign cpuOfs = cpuAddr[OFS_W-1:0];
  assign cpuIdx = cpuAddr[OFS_W+IDX_W-1:OFS_W];
  assign cpuTag = cpuAddr[ADDR_W-1:OFS_W+IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[LA_W-1:IDX_W];

  function automatic logic [LINE_W-1:0] mergeWord(
    input logic [LINE_W-1:0] line,
    input logic [OFS_W-1:0]  ofs,
    input logic [BE_W-1:0]   be,
    input logic [DATA_W-1:0] d
  );
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[int'(ofs)*DATA_W + b*8 +: 8] = d[b*8 +: 8];
    end
    return r;
  endfunction

  // Lookup
  assign cpuVicState = stateQ[cpuIdx];
  assign cpuMatch    = (stateQ[cpuIdx] != LS_NP) && (tagQ[cpuIdx] == cpuTag);
  assign snpState    = ((stateQ[snpIdx] != LS_NP) && (tagQ[snpIdx] == snpTag))
                       ? stateQ[snpIdx] : LS_NP;
  assign cpuRdata    = dataQ[cpuIdx][int'(cpuOfs)*DATA_W +: DATA_W];
  assign victimLine  = dataQ[cpuIdx];
  assign snpLine     = dataQ[snpIdx];
  assign reqAddr     = strb.selVictim ? {tagQ[cpuIdx], cpuIdx} : cpuAddr[ADDR_W-1:OFS_W];

  // Storage, one slice per line
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic cpuSel, snpSel;
    assign cpuSel = (cpuIdx == IDX_W'(g));
    assign snpSel = (snpIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ[g] <= LS_NP;
        tagQ[g]   <= '0;
        dataQ[g]  <= '0;
      end else begin
        if (cpuSel && strb.evict)       stateQ[g] <= LS_NP;
        if (cpuSel && strb.install) begin
          stateQ[g] <= strb.installState;
          tagQ[g]   <= cpuTag;
          dataQ[g]  <= fillLine;
        end
        if (cpuSel && strb.cpuWrWord)   dataQ[g]  <= mergeWord(dataQ[g], cpuOfs, cpuBe, cpuWdata);
        if (cpuSel && strb.cpuSetState) stateQ[g] <= strb.cpuNewState;
        if (snpSel && strb.snpWrWord)   dataQ[g]  <= mergeWord(dataQ[g], snpWord, snpBe, snpData);
        if (snpSel && strb.snpSetState) stateQ[g] <= strb.snpNewState;
      end
    end
  end

endmodule

// File: rtl/snoopUpdateCtl.sv
module snoopUpdateCtl
  import snoopUpdatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuValid,
  input  logic         cpuWrite,
  input  logic         cpuMatch,
  input  lineState_t   cpuVicState,
  input  logic         busDone,
  input  logic         busShared,
  input  logic         snpValid,
  input  logic [1:0]   snpCmd,
  input  lineState_t   snpState,
  output ctrlStrobes_t strb,
  output logic         cpuReady,
  output logic         cpuHit,
  output logic         busValid,
  output busCmd_t      busCmd,
  output logic         snpSharedOut,
  output logic         snpFlush
);

  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_FILL, PH_UPD} phase_t;

  phase_t phaseQ, phaseD;
  logic   missQ, missD;

  assign cpuHit = !missQ;

  always_comb begin
    strb         = '0;
    cpuReady     = 1'b0;
    busValid     = 1'b0;
    busCmd       = BC_NONE;
    snpSharedOut = 1'b0;
    snpFlush     = 1'b0;
    phaseD       = phaseQ;
    missD        = missQ;

    unique case (phaseQ)
      PH_IDLE: begin
        if (snpValid) begin
          if (snpState != LS_NP && snpCmd == BC_RD) begin
            snpSharedOut = 1'b1;
            if (isDirty(snpState)) begin
              snpFlush         = 1'b1;
              strb.snpSetState = 1'b1;
              strb.snpNewState = LS_SM;
            end else if (snpState == LS_E) begin
              strb.snpSetState = 1'b1;
              strb.snpNewState = LS_SC;
            end
          end else if (snpState != LS_NP && snpCmd == BC_UPD) begin
            snpSharedOut   = 1'b1;
            strb.snpWrWord = 1'b1;
            if (snpState == LS_SM) begin
              strb.snpSetState = 1'b1;
              strb.snpNewState = LS_SC;
            end
          end
        end else if (cpuValid) begin
          if (cpuMatch) begin
            if (!cpuWrite) begin
              cpuReady = 1'b1;
            end else if (cpuVicState == LS_E || cpuVicState == LS_M) begin
              cpuReady         = 1'b1;
              strb.cpuWrWord   = 1'b1;
              strb.cpuSetState = 1'b1;
              strb.cpuNewState = LS_M;
            end else begin
              phaseD = PH_UPD;
            end
          end else begin
            missD  = 1'b1;
            phaseD = isDirty(cpuVicState) ? PH_WB : PH_FILL;
          end
        end
      end
      PH_WB: begin
        busValid       = 1'b1;
        busCmd         = BC_WB;
        strb.selVictim = 1'b1;
        if (busDone) begin
          strb.evict = 1'b1;
          phaseD     = PH_FILL;
        end
      end
      PH_FILL: begin
        busValid = 1'b1;
        busCmd   = BC_RD;
        if (busDone) begin
          strb.install      = 1'b1;
          strb.installState = busShared ? LS_SC : LS_E;
          phaseD            = PH_IDLE;
        end
      end
      PH_UPD: begin
        busValid = 1'b1;
        busCmd   = BC_UPD;
        if (busDone) begin
          cpuReady         = 1'b1;
          strb.cpuWrWord   = 1'b1;
          strb.cpuSetState = 1'b1;
          strb.cpuNewState = busShared ? LS_SM : LS_M;
          phaseD           = PH_IDLE;
        end
      end
      default: phaseD = PH_IDLE;
    endcase

    if (cpuReady) missD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      missQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      missQ  <= missD;
    end
  end

endmodule

// File: rtl/snoopUpdateCtrl.sv
module snoopUpdateCtrl
  import snoopUpdatePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int LA_W   = ADDR_W - OFS_W,
  localparam int LINE_W = DATA_W * WORDS,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [BE_W-1:0]   cpuBe,
  output logic              cpuReady,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busValid,
  output logic [1:0]        busCmd,
  output logic [LA_W-1:0]   busAddr,
  output logic [OFS_W-1:0]  busWord,
  output logic [BE_W-1:0]   busBe,
  output logic [DATA_W-1:0] busWdata,
  output logic [LINE_W-1:0] busLine,
  input  logic              busDone,
  input  logic              busShared,
  input  logic [LINE_W-1:0] busFill,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [LA_W-1:0]   snpAddr,
  input  logic [OFS_W-1:0]  snpWord,
  input  logic [BE_W-1:0]   snpBe,
  input  logic [DATA_W-1:0] snpData,
  output logic              snpSharedOut,
  output logic              snpFlush,
  output logic [LINE_W-1:0] snpFlushLine
);

  ctrlStrobes_t strb;
  logic         cpuMatch;
  lineState_t   cpuVicState;
  lineState_t   snpState;
  busCmd_t      busCmdInt;

  assign busCmd   = busCmdInt;
  assign busWord  = cpuAddr[OFS_W-1:0];
  assign busBe    = cpuBe;
  assign busWdata = cpuWdata;

  snoopUpdateCtl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuValid     (cpuValid),
    .cpuWrite     (cpuWrite),
    .cpuMatch     (cpuMatch),
    .cpuVicState  (cpuVicState),
    .busDone      (busDone),
    .busShared    (busShared),
    .snpValid     (snpValid),
    .snpCmd       (snpCmd),
    .snpState     (snpState),
    .strb         (strb),
    .cpuReady     (cpuReady),
    .cpuHit       (cpuHit),
    .busValid     (busValid),
    .busCmd       (busCmdInt),
    .snpSharedOut (snpSharedOut),
    .snpFlush     (snpFlush)
  );

  snoopUpdateData #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .LINES  (LINES)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .cpuBe       (cpuBe),
    .fillLine    (busFill),
    .snpAddr     (snpAddr),
    .snpWord     (snpWord),
    .snpBe       (snpBe),
    .snpData     (snpData),
    .cpuMatch    (cpuMatch),
    .cpuVicState (cpuVicState),
    .snpState    (snpState),
    .cpuRdata    (cpuRdata),
    .reqAddr     (busAddr),
    .victimLine  (busLine),
    .snpLine     (snpFlushLine)
  );

endmodule

// File: rtl/snoopUpdateCtrl_chk.sv
module snoopUpdateCtrl_chk #(
  parameter int LA_W = 14
) (
  input logic            clk,
  input logic            rstN,
  input logic            cpuValid,
  input logic            cpuWrite,
  input logic            cpuReady,
  input logic            busValid,
  input logic [1:0]      busCmd,
  input logic [LA_W-1:0] busAddr,
  input logic            busDone,
  input logic            snpValid,
  input logic [1:0]      snpCmd,
  input logic            snpSharedOut,
  input logic            snpFlush
);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busDone |=> busValid && $stable(busCmd) && $stable(busAddr)); // R10

  AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> snpValid && snpCmd == 2'd1 && snpSharedOut); // R6

  AST_UPD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd2 |-> cpuValid && cpuWrite); // R4

  AST_SNOOP_TAKES_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && !busValid |-> !cpuReady); // R11

  AST_SNOOP_MUTE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !snpSharedOut && !snpFlush); // R11

  AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busCmd == 2'd3 && busDone |=> busValid && busCmd == 2'd1); // R9

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid); // R3

endmodule

bind snoopUpdateCtrl snoopUpdateCtrl_chk #(.LA_W(LA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuValid     (cpuValid),
  .cpuWrite     (cpuWrite),
  .cpuReady     (cpuReady),
  .busValid     (busValid),
  .busCmd       (busCmd),
  .busAddr      (busAddr),
  .busDone      (busDone),
  .snpValid     (snpValid),
  .snpCmd       (snpCmd),
  .snpSharedOut (snpSharedOut),
  .snpFlush     (snpFlush)
);

// File: tb/snoopUpdateCtrl_tb.sv
module snoopUpdateCtrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         cpuValid = 0, cpuWrite = 0;
  logic [15:0]  cpuAddr = 0;
  logic [31:0]  cpuWdata = 0;
  logic [3:0]   cpuBe = 0;
  logic         cpuReady, cpuHit;
  logic [31:0]  cpuRdata;
  logic         busValid;
  logic [1:0]   busCmd;
  logic [13:0]  busAddr;
  logic [1:0]   busWord;
  logic [3:0]   busBe;
  logic [31:0]  busWdata;
  logic [127:0] busLine;
  logic         busDone = 0, busShared = 0;
  logic [127:0] busFill = 0;
  logic         snpValid = 0;
  logic [1:0]   snpCmd = 0;
  logic [13:0]  snpAddr = 0;
  logic [1:0]   snpWord = 0;
  logic [3:0]   snpBe = 0;
  logic [31:0]  snpData = 0;
  logic         snpSharedOut, snpFlush;
  logic [127:0] snpFlushLine;

  snoopUpdateCtrl u_dut (.*);

  // Reference model. States: 0 absent, 1 E, 2 Sc, 3 Sm, 4 M
  int          mState [8];
  logic [10:0] mTag   [8];
  logic [31:0] mData  [8][4];
  int          mPhase;   // 0 idle, 1 write-back, 2 fill, 3 update
  bit          mMiss;
  int          waitCnt;

  bit           eReady, eHit, eBusValid, eShared, eFlush;
  logic [31:0]  eRdata;
  logic [1:0]   eCmd;
  logic [13:0]  eAddr;
  logic [127:0] eLine, eFlushLine;

  int    checks = 0, errors = 0;
  string curReq = "R1";
  bit    finished = 0;

  function automatic logic [31:0] fillWord(logic [13:0] la, int w);
    return {4'hA, la, 2'b01, 12'(w * 37 + 5)};
  endfunction

  function automatic logic [127:0] fillLineOf(logic [13:0] la);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = fillWord(la, w);
    return r;
  endfunction

  function automatic logic [127:0] modelLine(int idx);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = mData[idx][w];
    return r;
  endfunction

  function automatic logic [31:0] mergeBytes(logic [31:0] old, logic [3:0] be, logic [31:0] d);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic modelEval(bit commit);
    int ci, cw, si, st;
    bit cHit, sHit;
    ci = int'(cpuAddr[4:2]);
    cw = int'(cpuAddr[1:0]);
    si = int'(snpAddr[2:0]);
    cHit = (mState[ci] != 0) && (mTag[ci] == cpuAddr[15:5]);
    sHit = (mState[si] != 0) && (mTag[si] == snpAddr[13:3]);
    st = mState[si];
    eReady = 0; eHit = 0; eRdata = 0; eBusValid = 0; eCmd = 0; eAddr = 0;
    eLine = 0; eShared = 0; eFlush = 0; eFlushLine = 0;
    if (commit && !rstN) begin
      for (int i = 0; i < 8; i++) mState[i] = 0;
      mPhase = 0; mMiss = 0; waitCnt = 0;
      return;
    end
    case (mPhase)
      0: begin
        if (snpValid) begin
          if (sHit && snpCmd == 2'd1) begin
            eShared = 1;
            if (st == 3 || st == 4) begin
              eFlush = 1; eFlushLine = modelLine(si);
              if (commit) mState[si] = 3;
            end else if (st == 1 && commit) mState[si] = 2;
          end else if (sHit && snpCmd == 2'd2) begin
            eShared = 1;
            if (commit) begin
              mData[si][snpWord] = mergeBytes(mData[si][snpWord], snpBe, snpData);
              if (st == 3) mState[si] = 2;
            end
          end
        end else if (cpuValid) begin
          if (cHit && !cpuWrite) begin
            eReady = 1; eHit = !mMiss; eRdata = mData[ci][cw];
            if (commit) mMiss = 0;
          end else if (cHit && (mState[ci] == 1 || mState[ci] == 4)) begin
            eReady = 1; eHit = !mMiss;
            if (commit) begin
              mData[ci][cw] = mergeBytes(mData[ci][cw], cpuBe, cpuWdata);
              mState[ci] = 4; mMiss = 0;
            end
          end else if (cHit) begin
            if (commit) mPhase = 3;
          end else if (commit) begin
            mMiss = 1;
            mPhase = (mState[ci] == 3 || mState[ci] == 4) ? 1 : 2;
          end
        end
      end
      1: begin
        eBusValid = 1; eCmd = 2'd3; eAddr = {mTag[ci], 3'(ci)}; eLine = modelLine(ci);
        if (busDone && commit) begin mState[ci] = 0; mPhase = 2; end
      end
      2: begin
        eBusValid = 1; eCmd = 2'd1; eAddr = cpuAddr[15:2];
        if (busDone && commit) begin
          for (int w = 0; w < 4; w++) mData[ci][w] = busFill[w*32 +: 32];
          mTag[ci] = cpuAddr[15:5];
          mState[ci] = busShared ? 2 : 1;
          mPhase = 0;
        end
      end
      default: begin
        eBusValid = 1; eCmd = 2'd2; eAddr = cpuAddr[15:2];
        if (busDone) begin
          eReady = 1; eHit = !mMiss;
          if (commit) begin
            mData[ci][cw] = mergeBytes(mData[ci][cw], cpuBe, cpuWdata);
            mState[ci] = busShared ? 3 : 4;
            mMiss = 0; mPhase = 0;
          end
        end
      end
    endcase
  endtask

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("cpuReady", 128'(cpuReady), 128'(eReady));
    if (eReady) begin
      chk("cpuHit", 128'(cpuHit), 128'(eHit));
      if (!cpuWrite) chk("cpuRdata", 128'(cpuRdata), 128'(eRdata));
    end
    chk("busValid", 128'(busValid), 128'(eBusValid));
    if (eBusValid) begin
      chk("busCmd", 128'(busCmd), 128'(eCmd));
      chk("busAddr", 128'(busAddr), 128'(eAddr));
      if (eCmd == 2'd2) begin
        chk("busWord", 128'(busWord), 128'(cpuAddr[1:0]));
        chk("busBe", 128'(busBe), 128'(cpuBe));
        chk("busWdata", 128'(busWdata), 128'(cpuWdata));
      end
      if (eCmd == 2'd3) chk("busLine", busLine, eLine);
    end
    chk("snpSharedOut", 128'(snpSharedOut), 128'(eShared));
    chk("snpFlush", 128'(snpFlush), 128'(eFlush));
    if (eFlush) chk("snpFlushLine", snpFlushLine, eFlushLine);
  endtask

  bit lastReady;

  // One clock: inputs already set at the falling edge
  task automatic step();
    busDone = (mPhase != 0) && (waitCnt >= LAT);
    busFill = fillLineOf(cpuAddr[15:2]);
    #1;
    modelEval(0);
    lastReady = eReady;
    compareAll();
    @(posedge clk);
    if (mPhase != 0 && !busDone) waitCnt++; else waitCnt = 0;
    modelEval(1);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mkAddr(int tag, int idx, int w);
    return {11'(tag), 3'(idx), 2'(w)};
  endfunction

  task automatic runCpu(bit wr, logic [15:0] a, logic [31:0] d, logic [3:0] be, bit sh, int snpAt);
    cpuValid = 1; cpuWrite = wr; cpuAddr = a; cpuWdata = d; cpuBe = be; busShared = sh;
    for (int n = 0; n < 40; n++) begin
      snpValid = (n == snpAt);
      step();
      if (lastReady) break;
    end
    cpuValid = 0; snpValid = 0;
  endtask

  task automatic snoopOnce(logic [1:0] cmd, logic [13:0] la, int w, logic [3:0] be, logic [31:0] d);
    snpCmd = cmd; snpAddr = la; snpWord = 2'(w); snpBe = be; snpData = d;
    snpValid = 1;
    step();
    snpValid = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    finish();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mState[i] = 0; mTag[i] = 0;
      for (int w = 0; w < 4; w++) mData[i][w] = 0;
    end
    mPhase = 0; mMiss = 0; waitCnt = 0;
    @(negedge clk);
    // R1: reset quiet, then first access misses
    curReq = "R1";
    repeat (3) step();
    rstN = 1;
    step();
    snoopOnce(2'd1, {11'd5, 3'd1}, 0, 4'h0, 0);
    // R2: read miss, nobody shares -> exclusive
    curReq = "R2";
    runCpu(0, mkAddr(5, 1, 2), 0, 0, 0, -1);
    // R3: read hit
    curReq = "R3";
    runCpu(0, mkAddr(5, 1, 3), 0, 0, 0, -1);
    // R5: write hit on exclusive, silent
    curReq = "R5";
    runCpu(1, mkAddr(5, 1, 1), 32'h1234_5678, 4'b0101, 0, -1);
    // R6: snooped read of dirty line flushes, becomes shared-owned
    curReq = "R6";
    snoopOnce(2'd1, {11'd5, 3'd1}, 0, 0, 0);
    snoopOnce(2'd1, {11'd5, 3'd1}, 0, 0, 0);
    // R4: write on shared-owned, shared stays then drops
    curReq = "R4";
    runCpu(1, mkAddr(5, 1, 0), 32'hDEAD_BEEF, 4'b1111, 1, -1);
    runCpu(1, mkAddr(5, 1, 2), 32'hCAFE_F00D, 4'b0011, 0, -1);
    runCpu(0, mkAddr(5, 1, 2), 0, 0, 0, -1);
    // R2: read miss with shared line -> shared-clean
    curReq = "R2";
    runCpu(0, mkAddr(9, 2, 1), 0, 0, 1, -1);
    // R7: snooped update merges bytes
    curReq = "R7";
    snoopOnce(2'd2, {11'd9, 3'd2}, 1, 4'b1000, 32'h7700_0000);
    runCpu(0, mkAddr(9, 2, 1), 0, 0, 0, -1);
    curReq = "R4";
    runCpu(1, mkAddr(9, 2, 3), 32'h0BAD_CAFE, 4'b1100, 1, -1);
    curReq = "R7";
    snoopOnce(2'd2, {11'd9, 3'd2}, 3, 4'b0001, 32'h0000_0042);
    snoopOnce(2'd1, {11'd9, 3'd2}, 0, 0, 0);
    runCpu(0, mkAddr(9, 2, 3), 0, 0, 0, -1);
    // R6: exclusive line goes shared-clean on snooped read, write then updates
    curReq = "R6";
    runCpu(0, mkAddr(3, 3, 0), 0, 0, 0, -1);
    snoopOnce(2'd1, {11'd3, 3'd3}, 0, 0, 0);
    runCpu(1, mkAddr(3, 3, 0), 32'h5555_AAAA, 4'b1111, 0, -1);
    // R8: write misses, shared and private
    curReq = "R8";
    runCpu(1, mkAddr(7, 4, 2), 32'h1111_2222, 4'b1111, 1, -1);
    snoopOnce(2'd1, {11'd7, 3'd4}, 0, 0, 0);
    runCpu(1, mkAddr(8, 5, 1), 32'h3333_4444, 4'b0110, 0, -1);
    snoopOnce(2'd1, {11'd8, 3'd5}, 0, 0, 0);
    // R9: dirty victim written back, clean victim dropped
    curReq = "R9";
    runCpu(0, mkAddr(6, 1, 0), 0, 0, 0, -1);
    runCpu(0, mkAddr(6, 2, 0), 0, 0, 0, -1);
    runCpu(1, mkAddr(12, 4, 0), 32'h9999_0000, 4'b1111, 0, -1);
    // R11: snoop beats a hit in the same cycle; snoop ignored while busy
    curReq = "R11";
    snpCmd = 2'd1; snpAddr = {11'd6, 3'd1}; snpWord = 0; snpBe = 0; snpData = 0;
    runCpu(0, mkAddr(6, 1, 1), 0, 0, 0, 0);
    snpCmd = 2'd2; snpAddr = {11'd12, 3'd4}; snpWord = 0; snpBe = 4'hF; snpData = 32'hFFFF_FFFF;
    runCpu(0, mkAddr(2, 6, 0), 0, 0, 0, 1);
    runCpu(0, mkAddr(12, 4, 0), 0, 0, 0, -1);
    // R10: holding checked every cycle; trailing idle
    curReq = "R10";
    repeat (3) step();
    finish();
  end

endmodule